// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Tags

This block sits between a serial receiver's deserializer and the host. Each completed character arrives on a write strobe with its data byte and three error tags. The block stores it in a first-in first-out buffer with 128 entries of 11 bits each. The oldest entry is always visible on a read-only holding output. Each host read removes the head, and the tags of the next entry appear on the tag output straight after that read.

The block drives a data-ready flag and a receive interrupt. With buffering off, the store holds a single character and the interrupt fires for each character. With buffering on, the interrupt waits until occupancy reaches one of four trigger levels. A character-idle timeout still delivers data that sits below the trigger level. The timeout counts 16x bit-clock ticks up to four character lengths plus twelve bit times, and the character length follows a 2-bit word-length code. A write that finds the store full is dropped and sets a sticky overrun flag.

Top module: `rx_char_buffer`

## Requirements
- R1: With buffering enabled, the store accepts 128 characters. They are returned in write order, each with the three tags that were written with it.
- R2: The holding outputs show the oldest stored character. After each read edge, the tag output carries the tags of the new head entry.
- R3: A read strobe while data is held removes the head. A read strobe while empty moves nothing. When empty, the data output keeps the byte last read and the tag output is 0.
- R4: `data_ready` is 1 exactly when at least one character is held.
- R5: A write strobe while full, including one in the same cycle as a read, is discarded and sets `overrun`. `overrun` stays set until a cycle with `status_rd` high and no dropped write.
- R6: With buffering disabled (`fifo_en`=0), the capacity is one character. The interrupt is raised while that character is held.
- R7: With buffering enabled, the level interrupt is raised while occupancy is at least the trigger level and drops once occupancy falls below it. `trig_sel` 0, 1, 2, 3 selects 8, 16, 56, 60.
- R8: With buffering enabled and data held, `rx_timeout` rises after (4*(bits+2)+12)*16 consecutive ticks with no write and no read, where bits = 5 + `word_len`. Every accepted write or read restarts the count, and an empty store clears it. A timeout also raises the interrupt.
- R9: `rx_irq` is 0 whenever `irq_en` is 0.
- R10: After reset the store is empty, `hold_data` is 0, and `overrun`, `rx_timeout` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | 16x bit-clock enable |
| wr_strobe | input | 1 | Character complete from deserializer |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_strobe | input | 1 | Host read of holding register |
| status_rd | input | 1 | Host status read, clears overrun |
| fifo_en | input | 1 | Buffering enable |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Trigger level select |
| word_len | input | 2 | Word length code, 5 + value bits |
| hold_data | output | 8 | Head byte or last byte read |
| hold_tags | output | 3 | Head error tags, 0 when empty |
| data_ready | output | 1 | Data held |
| overrun | output | 1 | Sticky dropped-write flag |
| rx_timeout | output | 1 | Character-idle timeout |
| rx_irq | output | 1 | Receive interrupt |

## Verification
On every cycle the assertions check several invariants. Occupancy never exceeds the depth. A read without a write lowers occupancy by exactly one. A dropped write leaves `overrun` set, and `overrun` stays set until a status read. A timeout only rises after a quiet cycle and only while data is held. No interrupt appears while it is disabled. Some behaviour can only be shown by the bench's scenarios:
- the exact ordering of data and tags across a full wrap of the store;
- the byte kept after the store empties;
- the four trigger thresholds on both sides;
- the exact tick count of the timeout for different word lengths and after a restart.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  // Occupancy threshold for the level interrupt.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  // Idle limit in ticks: four characters (start + bits + stop) plus 12 bits.
  function automatic int tout_limit(input logic [1:0] wl, input int ticks);
    int char_bits;
    char_bits = 5 + int'(wl) + 2;
    return (4 * char_bits + 12) * ticks;
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int TW    = 3,
  localparam int EW   = DW + TW,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          cap_one,
  input  logic [EW-1:0] wr_entry,
  output logic [EW-1:0] head_entry,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_drop
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] last_q;
  logic          full;

  assign full      = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign push_ok   = push_req & ~full;
  assign push_drop = push_req & full;
  assign pop_ok    = pop_req & (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= bump(rd_ptr);
        last_q <= mem[rd_ptr][DW-1:0];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_entry = (count != '0) ? mem[rd_ptr] : {{TW{1'b0}}, last_q};
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer
  import rxb_pkg::*;
#(
  parameter int TICKS = 16,
  localparam int MAXL = (4 * (8 + 2) + 12) * TICKS,
  localparam int CW   = $clog2(MAXL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       nonempty,
  input  logic       restart,
  input  logic [1:0] word_len,
  output logic       tout
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  assign last_cnt = CW'(tout_limit(word_len, TICKS) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tout <= 1'b0;
    end else if (restart || !nonempty || !enable) begin
      cnt  <= '0;
      tout <= 1'b0;
    end else if (tick && !tout) begin
      if (cnt == last_cnt) tout <= 1'b1;
      else                 cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int TICKS = 16,
  localparam int EW   = DATA_W + TAG_W,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tags,
  input  logic              rd_strobe,
  input  logic              status_rd,
  input  logic              fifo_en,
  input  logic              irq_en,
  input  logic [1:0]        trig_sel,
  input  logic [1:0]        word_len,
  output logic [DATA_W-1:0] hold_data,
  output logic [TAG_W-1:0]  hold_tags,
  output logic              data_ready,
  output logic              overrun,
  output logic              rx_timeout,
  output logic              rx_irq
);
  logic [EW-1:0] head;
  logic [CW-1:0] occ;
  logic          push_ok, pop_ok, push_drop;
  logic          level_hit;

  rxb_store #(.DEPTH(DEPTH), .DW(DATA_W), .TW(TAG_W)) u_store (
    .clk, .rst_n,
    .push_req  (wr_strobe),
    .pop_req   (rd_strobe),
    .cap_one   (~fifo_en),
    .wr_entry  ({wr_tags, wr_data}),
    .head_entry(head),
    .count     (occ),
    .push_ok, .pop_ok, .push_drop
  );

  rxb_timer #(.TICKS(TICKS)) u_timer (
    .clk, .rst_n,
    .tick     (tick16),
    .enable   (fifo_en),
    .nonempty (data_ready),
    .restart  (push_ok | pop_ok),
    .word_len,
    .tout     (rx_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (push_drop) overrun <= 1'b1;
    else if (status_rd) overrun <= 1'b0;
  end

  assign hold_data  = head[DATA_W-1:0];
  assign hold_tags  = head[EW-1:DATA_W];
  assign data_ready = (occ != '0);
  assign level_hit  = fifo_en ? (int'(occ) >= trig_level(trig_sel)) : data_ready;
  assign rx_irq     = irq_en & (level_hit | rx_timeout);
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          push_drop,
  input logic [CW-1:0] occ,
  input logic          overrun,
  input logic          status_rd,
  input logic          rx_timeout,
  input logic          data_ready,
  input logic          rx_irq,
  input logic          irq_en
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (occ == $past(occ) - 1'b1));

  p_drop_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun);

  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);

  p_tout_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> data_ready);

  p_tout_after_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> $past(!push_ok && !pop_ok));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq);
endmodule

bind rx_char_buffer rxb_checker #(.DEPTH(DEPTH), .CW(CW)) i_rxb_checker (
  .clk, .rst_n, .push_ok, .pop_ok, .push_drop, .occ, .overrun,
  .status_rd, .rx_timeout, .data_ready, .rx_irq, .irq_en
);

// File: tb/test_rx_char_buffer.sv
module test_rx_char_buffer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick16 = 0, wr_strobe = 0, rd_strobe = 0, status_rd = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_tags = 0;
  logic       fifo_en = 1, irq_en = 1;
  logic [1:0] trig_sel = 0, word_len = 0;
  logic [7:0] hold_data;
  logic [2:0] hold_tags;
  logic       data_ready, overrun, rx_timeout, rx_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_char_buffer i_rx_char_buffer (.*);

  typedef struct packed { logic [1:0] sel; logic [7:0] n; logic exp; } trig_vec_t;
  localparam trig_vec_t TRIG_TAB [8] = '{
    '{2'd0, 8'd7, 1'b0}, '{2'd0, 8'd8, 1'b1},
    '{2'd1, 8'd15, 1'b0}, '{2'd1, 8'd16, 1'b1},
    '{2'd2, 8'd55, 1'b0}, '{2'd2, 8'd56, 1'b1},
    '{2'd3, 8'd59, 1'b0}, '{2'd3, 8'd60, 1'b1}};

  function automatic int idle_ticks(input int wl);
    return 16 * (12 + 4 * (wl + 7));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] t);
    @(negedge clk) begin wr_strobe = 1; wr_data = d; wr_tags = t; end
    @(negedge clk) wr_strobe = 0;
  endtask

  task automatic pop();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R10 ready", data_ready, 0);
    chk("R10 data", hold_data, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 irq", rx_irq + rx_timeout, 0);

    // R7 trigger table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      fifo_en = 1; irq_en = 1; tick16 = 0; trig_sel = TRIG_TAB[v].sel;
      for (int k = 0; k < int'(TRIG_TAB[v].n); k++) push(8'(k), 3'd0);
      chk("R7 level", rx_irq, TRIG_TAB[v].exp);
      if (TRIG_TAB[v].exp) begin
        pop();
        chk("R7 below", rx_irq, 0);
      end
    end

    // R1 R2 R4 R5 full store, order and tags
    do_reset();
    trig_sel = 3; tick16 = 0;
    for (int k = 0; k < 128; k++) push(8'(k + 3), 3'(k));
    chk("R5 no overrun at 128", overrun, 0);
    push(8'hEE, 3'd7);
    chk("R5 overrun set", overrun, 1);
    chk("R4 ready", data_ready, 1);
    for (int k = 0; k < 128; k++) begin
      chk("R1 data", hold_data, (k + 3) % 256);
      chk("R2 tags", hold_tags, k % 8);
      pop();
    end
    chk("R4 empty", data_ready, 0);
    chk("R3 last value", hold_data, 130);
    chk("R3 empty tags", hold_tags, 0);
    pop();
    chk("R3 empty read", hold_data, 130);
    push(8'h42, 3'd5);
    chk("R3 pointer kept", hold_data, 8'h42);
    chk("R2 head tags", hold_tags, 5);
    chk("R5 sticky", overrun, 1);
    @(negedge clk) status_rd = 1;
    @(negedge clk) status_rd = 0;
    chk("R5 cleared", overrun, 0);

    // R6 disabled mode
    do_reset();
    fifo_en = 0; irq_en = 1;
    chk("R6 idle irq", rx_irq, 0);
    push(8'h11, 3'd1);
    chk("R6 irq per char", rx_irq, 1);
    push(8'h22, 3'd2);
    chk("R6 capacity one", hold_data, 8'h11);
    chk("R6 overrun", overrun, 1);
    irq_en = 0;
    @(negedge clk);
    chk("R9 gated", rx_irq, 0);
    irq_en = 1;

    // R8 timeout, word_len 0
    do_reset();
    fifo_en = 1; trig_sel = 3; word_len = 0; tick16 = 1;
    push(8'h55, 3'd0);
    repeat (idle_ticks(0) - 1) @(negedge clk);
    chk("R8 before limit", rx_timeout, 0);
    @(negedge clk);
    chk("R8 at limit", rx_timeout, 1);
    chk("R8 irq", rx_irq, 1);
    pop();
    chk("R8 cleared empty", rx_timeout, 0);

    // R8 restart, word_len 3
    word_len = 3;
    push(8'h66, 3'd0);
    repeat (400) @(negedge clk);
    push(8'h67, 3'd0);
    repeat (idle_ticks(3) - 1) @(negedge clk);
    chk("R8 restart before", rx_timeout, 0);
    @(negedge clk);
    chk("R8 restart at limit", rx_timeout, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule